// File: doc/BRIEF.md
# Two-Bank Flow-Through Synchronous Burst SRAM

This block models a synchronous burst static memory made of two banks that share one address bus, one clock and one data path. On each rising clock edge it captures the address, two active-low bank enables, an active-low global write and three burst controls. The controls are an active-low processor-side address strobe, an active-low controller-side address strobe and an active-low advance. A two-bit burst sequencer steps through the four words of an aligned group, in either linear or interleaved order. Reads are flow-through: the word at the captured address is presented combinationally from the array in the cycle after the edge, with no output register. A burst therefore delivers data 2-1-1-1. Writes are self-timed and complete on the same edge that captures them.

Each stored word is 72 bits: 64 data bits plus one parity bit per data byte, stored and returned unchanged. An asynchronous active-low output enable gates the read bus. Each bank has an active-high snooze input that puts it into standby. In standby the bank keeps its contents, drives nothing and ignores accesses. The data path is split into a write-data input, a read-data output and a drive-enable output, which an outer level can turn into a shared three-state bus. Array depth per bank is a parameter.

Tying the controller strobe low and the processor strobe and advance high turns the block into a plain synchronous memory with single-cycle accesses.

Top module: `flowthru_burst_sram`

## Requirements
- R1: After reset no bank holds a burst, and `rdDrive` is 0.
- R2: At an edge where `procStrobeN`=0 and a bank is granted, that bank captures `addr` and starts a read, whatever `globalWrN` is. In the cycle right after that edge, `rdDrive`=1 and `rdData` is the word stored at `addr`, provided `outEnN`=0. Nothing is written.
- R3: `procStrobeN`=0 has no effect on a bank that is not granted. With `ctrlStrobeN`=1, such a bank treats the edge as a continue cycle, and `advN`=1 keeps its current address.
- R4: At an edge where `ctrlStrobeN`=0, `procStrobeN`=1 and a bank is granted, that bank captures `addr`. If `globalWrN`=0 it writes `wrData` there on that edge and does not drive. If `globalWrN`=1 it reads that word in the next cycle.
- R5: At an edge where `ctrlStrobeN`=0, every bank that is not granted ends its burst. It drives nothing until it captures a new address.
- R6: At an edge where both strobes are 1, `advN`=0 and `interleave`=0, an active bank steps its burst count k (1, 2, 3, then 0 again). The two low address bits become (start + k) mod 4, and the upper bits stay unchanged.
- R7: With `interleave`=1, the same step sets the two low address bits to start XOR k.
- R8: At a continue edge with `advN`=1, the bank keeps its address. In any continue cycle, `globalWrN`=0 writes `wrData` to the address after the step (the next address or the held one), and the bank does not drive in the following cycle. `globalWrN`=1 makes the bank read in the following cycle.
- R9: While `outEnN`=1, `rdDrive` is 0 at once, without waiting for a clock edge, even during a read burst.
- R10: While `snooze[b]`=1, bank b drives nothing at once. At an edge, bank b writes nothing and ends its burst. Its stored words are kept, and the other bank keeps working.
- R11: A bank is granted when its enable is 0 and no lower-numbered enable is 0. With `bankEnN`=2'b00, bank 0 alone is granted, and only bank 0 is read or written.
- R12: Each word is 72 bits: data byte n occupies bits 8n+7..8n, and its parity bit occupies bit 64+n. All 72 bits are written together and returned unchanged on a read.
- R13: With `ctrlStrobeN`=0 and `procStrobeN`=`advN`=1 held, each edge performs one complete access at a new address: a write if `globalWrN`=0, otherwise a read presented in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all captures on the rising edge |
| rst_n | input | 1 | Active-low reset of burst state (array contents are not reset) |
| addr | input | ADDR_W | Word address within a bank |
| bankEnN | input | NBANK | Active-low bank enables, bit 0 has priority |
| procStrobeN | input | 1 | Active-low processor-side address strobe (read only) |
| ctrlStrobeN | input | 1 | Active-low controller-side address strobe |
| advN | input | 1 | Active-low burst advance |
| globalWrN | input | 1 | Active-low write of the whole word |
| outEnN | input | 1 | Asynchronous active-low output enable |
| interleave | input | 1 | Burst order: 0 linear, 1 interleaved |
| snooze | input | NBANK | Active-high per-bank standby |
| wrData | input | 9*BYTES | Write word: data bytes then parity bits |
| rdData | output | 9*BYTES | Read word, zero when not driving |
| rdDrive | output | 1 | High when the read bus is driven |

## Verification
Every edge-captured result appears in the cycle after the capturing edge, through one state register and the combinational array read. The bench drives inputs just after a falling edge and updates its behavioural model at the rising edge. It compares `rdDrive` and the full 72-bit `rdData` at the next falling edge, every cycle. The two asynchronous paths, output enable and snooze, act with no edge in between: the bench changes those inputs mid-cycle and compares one nanosecond later. The burst-order checks cover a start address whose linear and interleaved orders differ, including the wrap back to the starting word.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  // Per-bank command strobes from the control to the datapath
  typedef struct packed {
    logic load;   // capture the external address
    logic step;   // advance the burst count
    logic wr;     // write wrData at the target address this edge
    logic kill;   // end the current burst
  } bankCmd_t;

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int NBANK = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NBANK-1:0]        bankEnN,
  input  logic                    procStrobeN,
  input  logic                    ctrlStrobeN,
  input  logic                    advN,
  input  logic                    globalWrN,
  input  logic [NBANK-1:0]        snooze,
  output bankCmd_t [NBANK-1:0]    cmd,
  output logic [NBANK-1:0]        readOn
);

  // Lowest-numbered enabled bank wins the shared bus
  logic [NBANK-1:0] granted;

  always_comb begin
    logic lowerTaken;
    lowerTaken = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      granted[b] = !bankEnN[b] && !lowerTaken;
      lowerTaken = lowerTaken | !bankEnN[b];
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bankCmd_t c;
    logic     rdNext;
    logic     active;
    logic     isRd;

    always_comb begin
      c      = '0;
      rdNext = 1'b1;
      if (snooze[b]) begin
        c.kill = 1'b1;
      end else if (!procStrobeN && granted[b]) begin
        c.load = 1'b1;
        rdNext = 1'b1;
      end else if (!ctrlStrobeN && granted[b]) begin
        c.load = 1'b1;
        c.wr   = !globalWrN;
        rdNext = globalWrN;
      end else if (!ctrlStrobeN) begin
        c.kill = 1'b1;
      end else if (active) begin
        c.step = !advN;
        c.wr   = !globalWrN;
        rdNext = globalWrN;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        active <= 1'b0;
        isRd   <= 1'b0;
      end else begin
        if (c.kill)      active <= 1'b0;
        else if (c.load) active <= 1'b1;
        if (c.load || (active && !c.kill)) isRd <= rdNext;
      end
    end

    assign cmd[b]    = c;
    assign readOn[b] = active && isRd;
  end

endmodule

// File: rtl/sbsram_dpath.sv
module sbsram_dpath
  import sbsram_pkg::*;
#(
  parameter int NBANK   = 2,
  parameter int ADDR_W  = 6,
  parameter int WORD_W  = 72,
  parameter int BURST_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  bankCmd_t [NBANK-1:0]  cmd,
  input  logic [NBANK-1:0]      readOn,
  input  logic [NBANK-1:0]      snooze,
  input  logic                  outEnN,
  input  logic                  interleave,
  input  logic [ADDR_W-1:0]     extAddr,
  input  logic [WORD_W-1:0]     wrData,
  output logic [WORD_W-1:0]     rdData,
  output logic                  rdDrive
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] bankWord [NBANK];
  logic [NBANK-1:0]  bankRd;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [WORD_W-1:0]  mem [DEPTH];
    logic [ADDR_W-1:0]  curAddr;
    logic [BURST_W-1:0] startLow;
    logic [BURST_W-1:0] cnt;
    logic [BURST_W-1:0] nextCnt;
    logic [BURST_W-1:0] nextLow;
    logic [ADDR_W-1:0]  stepAddr;
    logic [ADDR_W-1:0]  target;

    assign nextCnt  = cnt + BURST_W'(1);
    assign nextLow  = interleave ? (startLow ^ nextCnt) : (startLow + nextCnt);
    assign stepAddr = {curAddr[ADDR_W-1:BURST_W], nextLow};

    always_comb begin
      if (cmd[b].load)      target = extAddr;
      else if (cmd[b].step) target = stepAddr;
      else                  target = curAddr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        curAddr  <= '0;
        startLow <= '0;
        cnt      <= '0;
      end else begin
        if (cmd[b].load) begin
          startLow <= extAddr[BURST_W-1:0];
          cnt      <= '0;
        end else if (cmd[b].step) begin
          cnt <= nextCnt;
        end
        if (cmd[b].load || cmd[b].step) curAddr <= target;
      end
    end

    // Self-timed write: completes on the capturing edge
    always_ff @(posedge clk) begin
      if (cmd[b].wr) mem[target] <= wrData;
    end

    // Flow-through read: no output register
    assign bankWord[b] = mem[curAddr];
    assign bankRd[b]   = readOn[b] && !snooze[b];
  end

  logic [WORD_W-1:0] selWord;

  always_comb begin
    selWord = '0;
    for (int b = NBANK - 1; b >= 0; b--) begin
      if (bankRd[b]) selWord = bankWord[b];
    end
  end

  assign rdDrive = (|bankRd) && !outEnN;
  assign rdData  = rdDrive ? selWord : '0;

endmodule

// File: rtl/flowthru_burst_sram.sv
module flowthru_burst_sram
  import sbsram_pkg::*;
#(
  parameter int NBANK  = 2,
  parameter int ADDR_W = 6,
  parameter int BYTES  = 8,
  localparam int WORD_W = 9 * BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NBANK-1:0]  bankEnN,
  input  logic              procStrobeN,
  input  logic              ctrlStrobeN,
  input  logic              advN,
  input  logic              globalWrN,
  input  logic              outEnN,
  input  logic              interleave,
  input  logic [NBANK-1:0]  snooze,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdDrive
);

  bankCmd_t [NBANK-1:0] cmd;
  logic [NBANK-1:0]     readOn;

  sbsram_ctrl #(.NBANK(NBANK)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .bankEnN     (bankEnN),
    .procStrobeN (procStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advN        (advN),
    .globalWrN   (globalWrN),
    .snooze      (snooze),
    .cmd         (cmd),
    .readOn      (readOn)
  );

  sbsram_dpath #(
    .NBANK   (NBANK),
    .ADDR_W  (ADDR_W),
    .WORD_W  (WORD_W),
    .BURST_W (2)
  ) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .readOn     (readOn),
    .snooze     (snooze),
    .outEnN     (outEnN),
    .interleave (interleave),
    .extAddr    (addr),
    .wrData     (wrData),
    .rdData     (rdData),
    .rdDrive    (rdDrive)
  );

endmodule

// File: rtl/flowthru_burst_sram_chk.sv
module flowthru_burst_sram_chk #(
  parameter int NBANK = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NBANK-1:0] bankEnN,
  input logic             procStrobeN,
  input logic             ctrlStrobeN,
  input logic             globalWrN,
  input logic             outEnN,
  input logic [NBANK-1:0] snooze,
  input logic             rdDrive
);

  // R9
  oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outEnN |-> !rdDrive);

  // R10
  all_snooze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&snooze) |-> !rdDrive);

  // R5
  deselect_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlStrobeN && (&bankEnN)) |=> !rdDrive);

  // R4
  ctrl_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrlStrobeN && procStrobeN && !globalWrN && !(&bankEnN) && snooze == '0)
      |=> !rdDrive);

  // R2
  proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!procStrobeN && !bankEnN[0] && !snooze[0])
      |=> (outEnN || snooze[0] || rdDrive));

endmodule

bind flowthru_burst_sram flowthru_burst_sram_chk #(.NBANK(NBANK)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bankEnN     (bankEnN),
  .procStrobeN (procStrobeN),
  .ctrlStrobeN (ctrlStrobeN),
  .globalWrN   (globalWrN),
  .outEnN      (outEnN),
  .snooze      (snooze),
  .rdDrive     (rdDrive)
);

// File: tb/test_flowthru_burst_sram.sv
module test_flowthru_burst_sram;

  localparam int AW = 6;
  localparam int WW = 72;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0]    bankEnN = 2'b11;
  logic          procStrobeN = 1'b1;
  logic          ctrlStrobeN = 1'b1;
  logic          advN = 1'b1;
  logic          globalWrN = 1'b1;
  logic          outEnN = 1'b0;
  logic          interleave = 1'b0;
  logic [1:0]    snooze = 2'b00;
  logic [WW-1:0] wrData = '0;
  logic [WW-1:0] rdData;
  logic          rdDrive;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  flowthru_burst_sram #(.NBANK(2), .ADDR_W(AW), .BYTES(8)) i_flowthru_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .bankEnN(bankEnN),
    .procStrobeN(procStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .globalWrN(globalWrN), .outEnN(outEnN), .interleave(interleave),
    .snooze(snooze), .wrData(wrData), .rdData(rdData), .rdDrive(rdDrive)
  );

  // Behavioural reference state
  logic [WW-1:0] mMem [2][64];
  bit mAct [2];
  bit mRd [2];
  int mAddr [2];
  int mStart [2];
  int mCnt [2];

  // R12 word pattern: parity bits (71:64) differ from data bytes
  function automatic logic [WW-1:0] pat(int b, int a);
    logic [63:0] d;
    logic [7:0]  p;
    d = (64'(a) * 64'h0123_4567_89AB_CDEF) ^ (64'(b) << 63) ^ 64'h5A5A_0000_0000_A5A5;
    p = 8'(a * 37 + b * 91 + 3);
    return {p, d};
  endfunction

  task automatic modelEdge();
    for (int b = 0; b < 2; b++) begin
      bit g;
      g = (b == 0) ? !bankEnN[0] : (!bankEnN[1] && bankEnN[0]);
      if (snooze[b]) begin
        mAct[b] = 0;
      end else if (!procStrobeN && g) begin
        mAct[b] = 1; mRd[b] = 1; mAddr[b] = int'(addr);
        mStart[b] = int'(addr) % 4; mCnt[b] = 0;
      end else if (!ctrlStrobeN && g) begin
        mAct[b] = 1; mAddr[b] = int'(addr);
        mStart[b] = int'(addr) % 4; mCnt[b] = 0;
        if (!globalWrN) mMem[b][mAddr[b]] = wrData;
        mRd[b] = globalWrN;
      end else if (!ctrlStrobeN) begin
        mAct[b] = 0;
      end else if (mAct[b]) begin
        if (!advN) begin
          int low;
          mCnt[b] = (mCnt[b] + 1) % 4;
          low = interleave ? (mStart[b] ^ mCnt[b]) : ((mStart[b] + mCnt[b]) % 4);
          mAddr[b] = (mAddr[b] / 4) * 4 + low;
        end
        if (!globalWrN) mMem[b][mAddr[b]] = wrData;
        mRd[b] = globalWrN;
      end
    end
  endtask

  task automatic compare(input string tag);
    bit            eDrv;
    logic [WW-1:0] eDat;
    eDrv = 0;
    eDat = '0;
    for (int b = 1; b >= 0; b--) begin
      if (mAct[b] && mRd[b] && !snooze[b]) begin
        eDrv = 1;
        eDat = mMem[b][mAddr[b]];
      end
    end
    if (outEnN) eDrv = 0;
    checks++;
    if (rdDrive !== eDrv || (eDrv && rdData !== eDat)) begin
      failures++;
      $display("FAIL %s: drive=%0b data=%h expected drive=%0b data=%h",
               tag, rdDrive, rdData, eDrv, eDat);
    end
  endtask

  task automatic tick(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compare(tag);
  endtask

  task automatic drive(input logic [1:0] en, input logic p, input logic c,
                       input logic a, input logic g, input int ad,
                       input logic [WW-1:0] d);
    bankEnN = en; procStrobeN = p; ctrlStrobeN = c; advN = a;
    globalWrN = g; addr = AW'(ad); wrData = d;
  endtask

  initial begin
    for (int b = 0; b < 2; b++) begin
      mAct[b] = 0; mRd[b] = 0; mAddr[b] = 0; mStart[b] = 0; mCnt[b] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    compare("R1");
    tick("R1");

    // R13 synchronous-only writes into both banks
    for (int a = 0; a < 16; a++) begin
      drive(2'b10, 1, 0, 1, 0, a, pat(0, a)); tick("R13");
    end
    for (int a = 0; a < 16; a++) begin
      drive(2'b01, 1, 0, 1, 0, a, pat(1, a)); tick("R13");
    end
    // R13 / R12 single-cycle reads
    for (int a = 0; a < 4; a++) begin
      drive(2'b10, 1, 0, 1, 1, a, '0); tick("R12");
    end
    drive(2'b01, 1, 0, 1, 1, 9, '0); tick("R4");

    // R2 processor-strobe read with global write low (no write)
    interleave = 0;
    drive(2'b10, 0, 1, 1, 0, 5, '1); tick("R2");
    // R6 linear from 5: 6, 7, 4, then back to 5
    for (int i = 0; i < 4; i++) begin
      drive(2'b11, 1, 1, 0, 1, 0, '0); tick("R6");
    end
    // R8 hold
    drive(2'b11, 1, 1, 1, 1, 0, '0); tick("R8");
    tick("R8");

    // R7 interleaved from 5: 4, 7, 6
    interleave = 1;
    drive(2'b10, 0, 1, 1, 1, 5, '0); tick("R7");
    for (int i = 0; i < 4; i++) begin
      drive(2'b11, 1, 1, 0, 1, 0, '0); tick("R7");
    end
    interleave = 0;

    // R8 continue writes: next address, then held address
    drive(2'b01, 1, 0, 1, 0, 20, pat(1, 20)); tick("R8");
    drive(2'b11, 1, 1, 0, 0, 0, pat(1, 21)); tick("R8");
    drive(2'b11, 1, 1, 1, 0, 0, ~pat(1, 21)); tick("R8");
    drive(2'b01, 1, 0, 1, 1, 21, '0); tick("R8");
    drive(2'b01, 1, 0, 1, 1, 20, '0); tick("R8");

    // R3 processor strobe ignored by a bank without grant
    drive(2'b11, 0, 1, 1, 1, 3, '0); tick("R3");
    tick("R3");

    // R9 asynchronous output enable
    #1 outEnN = 1'b1;
    #1 compare("R9");
    drive(2'b11, 1, 1, 1, 1, 0, '0); tick("R9");
    outEnN = 1'b0;
    #1 compare("R9");

    // R5 deselect by controller strobe
    drive(2'b11, 1, 0, 1, 1, 0, '0); tick("R5");
    drive(2'b11, 1, 1, 1, 1, 0, '0); tick("R5");

    // R11 both enables low: bank 0 only
    drive(2'b00, 0, 1, 1, 1, 3, '0); tick("R11");
    drive(2'b00, 1, 0, 1, 0, 2, ~pat(0, 2)); tick("R11");
    drive(2'b01, 1, 0, 1, 1, 2, '0); tick("R11");
    drive(2'b10, 1, 0, 1, 1, 2, '0); tick("R11");

    // R10 snooze
    drive(2'b10, 1, 0, 1, 1, 1, '0); tick("R10");
    #1 snooze = 2'b01;
    #1 compare("R10");
    drive(2'b10, 1, 0, 1, 0, 1, '1); tick("R10");
    drive(2'b01, 1, 0, 1, 1, 3, '0); tick("R10");
    drive(2'b11, 1, 0, 1, 1, 0, '0);
    snooze = 2'b00;
    tick("R10");
    drive(2'b10, 1, 0, 1, 1, 1, '0); tick("R10");
    drive(2'b11, 1, 1, 1, 1, 0, '0); tick("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule